// File: doc/BRIEF.md
# Speculative Credit-Based Link Sender

This block drives one point-to-point flit link under credit-based flow control. It keeps a signed count of the receiver's free buffer slots. While that count is positive it sends words against credit. When the count has reached zero or below and no credited word can go, it sends a newly arrived cell speculatively and marks it with a flag on the link. Every cell it accepts is held in a small retransmit store until the receiver acknowledges it positively. The receiver may drop a speculative cell when its buffer is full and answer with a negative acknowledgement. That cell then waits in the store and goes out again only under credit.

Each cell on the link carries a tag that names the store slot holding it. The receiver echoes that tag with its ACK or NACK. A NACK also returns the credit that the dropped cell had consumed, so the counter stays equal to the receiver's free space minus the cells still in flight. Credited cells can never be dropped, whatever the receiver depth. Full throughput needs a receive depth equal to the number of registers in the credit loop.

Top module: `spec_credit_tx`

## Requirements
- R1: After a synchronous active-low reset the credit count equals RX_DEPTH, `lnk_valid` is 0 and every store slot is free, so `in_ready` is 1.
- R2: A cell goes out without the speculative flag only if the credit count was above zero in that cycle. Every cell sent, speculative or not, lowers the count by one. A `crd_upd` pulse raises it by one. A pulse and a send in the same cycle leave the count unchanged, including at zero.
- R3: The credit count never rises above RX_DEPTH and never falls below minus SLOTS.
- R4: A new cell is sent speculatively, with `lnk_spec` = 1, exactly when it is accepted while the credit count is zero or below. Speculation is therefore used only when no credited transmission is possible.
- R5: `ack_valid` with `ack_nack` = 1 (NACK) moves the tagged cell to the pending-retransmit state and returns one credit. A retransmission is sent only with credit and never carries `lnk_spec`. As a result, a cell goes out speculatively at most once.
- R6: While the credit count is above zero and a NACKed cell is pending, that cell is sent next (the lowest-numbered pending slot goes first), and `in_ready` is 0.
- R7: A cell occupies its slot from acceptance until `ack_valid` with `ack_nack` = 0 (ACK) arrives for its tag. While all SLOTS slots are occupied, `in_ready` is 0.
- R8: `lnk_tag` is the index of the store slot holding the cell, and `ack_tag` selects the slot that an ACK or NACK applies to.
- R9: With a receiver that drops only when full, no credited cell ever meets a full receive buffer, and every accepted word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A new word is offered |
| in_data | input | DATA_W | Offered word |
| in_ready | output | 1 | The word is taken in this cycle if in_valid is 1 |
| lnk_valid | output | 1 | Link carries a cell |
| lnk_data | output | DATA_W | Cell payload |
| lnk_tag | output | TAG_W | Store slot of the cell |
| lnk_spec | output | 1 | Cell was sent without credit |
| crd_upd | input | 1 | Receiver freed one buffer slot |
| ack_valid | input | 1 | Acknowledgement present |
| ack_tag | input | TAG_W | Slot the acknowledgement refers to |
| ack_nack | input | 1 | 1 = NACK (dropped), 0 = ACK |

## Verification
The hardest case to reach is a NACK that lands while credit is positive and a new word is waiting, because retransmission priority only shows there. It needs a receive buffer that fills, then a speculative drop, then a credit return soon after. The stimulus first starves the receiver's drain so that speculative cells are dropped and NACKed. It then releases the drain and moves through random drain rates, so that credit returns and NACKs interleave in many different orders.

// File: rtl/spct_pkg.sv
package spct_pkg;
    // State of one retransmit-store slot
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_SENT = 2'd1,
        SL_RETX = 2'd2
    } slot_st_e;
endpackage

// File: rtl/spct_credit.sv
module spct_credit #(
    parameter int RX_DEPTH = 3,
    parameter int SLOTS    = 4,
    parameter int CW       = $clog2(RX_DEPTH + SLOTS + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic                 refund,
    input  logic                 take,
    output logic signed [CW-1:0] count,
    output logic                 has_credit
);
    localparam logic signed [CW-1:0] ONE  = CW'(1);
    localparam logic signed [CW-1:0] ZERO = '0;
    localparam logic signed [CW-1:0] INIT = CW'(RX_DEPTH);

    typedef struct packed {
        logic signed [CW-1:0] cnt;
    } cr_st_t;

    cr_st_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        if (upd)    cr_d.cnt = cr_d.cnt + ONE;
        if (refund) cr_d.cnt = cr_d.cnt + ONE;
        if (take)   cr_d.cnt = cr_d.cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '{cnt: INIT};
        else        cr_q <= cr_d;
    end

    assign count      = cr_q.cnt;
    assign has_credit = (cr_q.cnt > ZERO);
endmodule

// File: rtl/spct_store.sv
module spct_store
    import spct_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int DATA_W = 16,
    parameter int TAG_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              resend,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_nack,
    output logic              free_any,
    output logic [TAG_W-1:0]  free_idx,
    output logic              retx_any,
    output logic [TAG_W-1:0]  retx_idx,
    output logic [DATA_W-1:0] retx_data,
    output logic [SLOTS-1:0]  busy
);
    typedef struct packed {
        slot_st_e [SLOTS-1:0]              st;
        logic     [SLOTS-1:0][DATA_W-1:0]  data;
    } store_t;

    store_t sto_d, sto_q;

    // Lowest-index free slot and lowest-index pending retransmission
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        retx_any = 1'b0;
        retx_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (sto_q.st[i] == SL_FREE) begin
                free_any = 1'b1;
                free_idx = TAG_W'(i);
            end
            if (sto_q.st[i] == SL_RETX) begin
                retx_any = 1'b1;
                retx_idx = TAG_W'(i);
            end
        end
    end

    assign retx_data = sto_q.data[retx_idx];

    for (genvar g = 0; g < SLOTS; g++) begin : g_busy
        assign busy[g] = (sto_q.st[g] != SL_FREE);
    end

    always_comb begin
        sto_d = sto_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (ack_valid && ack_tag == TAG_W'(i) && sto_q.st[i] == SL_SENT)
                sto_d.st[i] = ack_nack ? SL_RETX : SL_FREE;
            if (alloc && free_idx == TAG_W'(i)) begin
                sto_d.st[i]   = SL_SENT;
                sto_d.data[i] = alloc_data;
            end
            if (resend && retx_idx == TAG_W'(i))
                sto_d.st[i] = SL_SENT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sto_q <= '0;
        else        sto_q <= sto_d;
    end
endmodule

// File: rtl/spct_pick.sv
module spct_pick (
    input  logic has_credit,
    input  logic retx_any,
    input  logic free_any,
    input  logic in_valid,
    output logic in_ready,
    output logic do_new,
    output logic do_resend,
    output logic spec
);
    always_comb begin
        do_resend = has_credit & retx_any;     // replays only under credit
        in_ready  = free_any & ~do_resend;     // replay beats new cells
        do_new    = in_valid & in_ready;
        spec      = do_new & ~has_credit;      // no credited cell eligible
    end
endmodule

// File: rtl/spec_credit_tx.sv
module spec_credit_tx #(
    parameter int DATA_W   = 16,
    parameter int SLOTS    = 4,
    parameter int RX_DEPTH = 3,
    parameter int TAG_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              lnk_valid,
    output logic [DATA_W-1:0] lnk_data,
    output logic [TAG_W-1:0]  lnk_tag,
    output logic              lnk_spec,
    input  logic              crd_upd,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_nack
);
    localparam int CW = $clog2(RX_DEPTH + SLOTS + 1) + 1;

    typedef struct packed {
        logic              valid;
        logic              spec;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t lnk_d, lnk_q;

    logic signed [CW-1:0] credit_cnt;
    logic                 has_credit;
    logic                 free_any, retx_any;
    logic [TAG_W-1:0]     free_idx, retx_idx;
    logic [DATA_W-1:0]    retx_data;
    logic [SLOTS-1:0]     slot_busy;
    logic                 do_new, do_resend, send_spec;

    spct_credit #(.RX_DEPTH(RX_DEPTH), .SLOTS(SLOTS), .CW(CW)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (crd_upd),
        .refund     (ack_valid & ack_nack),
        .take       (do_new | do_resend),
        .count      (credit_cnt),
        .has_credit (has_credit)
    );

    spct_store #(.SLOTS(SLOTS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (do_new),
        .alloc_data (in_data),
        .resend     (do_resend),
        .ack_valid  (ack_valid),
        .ack_tag    (ack_tag),
        .ack_nack   (ack_nack),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .retx_any   (retx_any),
        .retx_idx   (retx_idx),
        .retx_data  (retx_data),
        .busy       (slot_busy)
    );

    spct_pick u_pick (
        .has_credit (has_credit),
        .retx_any   (retx_any),
        .free_any   (free_any),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .do_new     (do_new),
        .do_resend  (do_resend),
        .spec       (send_spec)
    );

    always_comb begin
        lnk_d       = '0;
        lnk_d.valid = do_new | do_resend;
        lnk_d.spec  = send_spec;
        lnk_d.tag   = do_resend ? retx_idx  : free_idx;
        lnk_d.data  = do_resend ? retx_data : in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lnk_q <= '0;
        else        lnk_q <= lnk_d;
    end

    assign lnk_valid = lnk_q.valid;
    assign lnk_spec  = lnk_q.spec;
    assign lnk_tag   = lnk_q.tag;
    assign lnk_data  = lnk_q.data;
endmodule

// File: rtl/spct_checker.sv
module spct_checker #(
    parameter int SLOTS    = 4,
    parameter int RX_DEPTH = 3,
    parameter int CW       = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lnk_valid,
    input logic                 lnk_spec,
    input logic                 in_ready,
    input logic                 crd_upd,
    input logic                 ack_valid,
    input logic                 ack_nack,
    input logic signed [CW-1:0] credit,
    input logic [SLOTS-1:0]     busy
);
    int cr_i;
    assign cr_i = int'(credit);

    // R3: counter stays inside its legal window
    p_cr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_i <= RX_DEPTH) && (cr_i >= -SLOTS));

    // R2: an unflagged cell needs credit in the cycle it was chosen
    p_credited_needs_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && !lnk_spec) |-> ($past(cr_i) > 0));

    // R4: a flagged cell appears only when credit was exhausted
    p_spec_no_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_spec) |-> ($past(cr_i) <= 0));

    // R2 / R5: count moves by returns minus cells sent
    p_cr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cr_i == $past(cr_i) + int'($past(crd_upd))
                  + int'($past(ack_valid && ack_nack)) - int'(lnk_valid)));

    // R7: a full store refuses new words
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !in_ready);
endmodule

bind spec_credit_tx spct_checker #(.SLOTS(SLOTS), .RX_DEPTH(RX_DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lnk_valid (lnk_valid),
    .lnk_spec  (lnk_spec),
    .in_ready  (in_ready),
    .crd_upd   (crd_upd),
    .ack_valid (ack_valid),
    .ack_nack  (ack_nack),
    .credit    (credit_cnt),
    .busy      (slot_busy)
);

// File: tb/tb_spec_credit_tx.sv
module tb_spec_credit_tx;
    localparam int CLK_P  = 10;
    localparam int DW     = 16;
    localparam int SL     = 4;
    localparam int RXD    = 3;
    localparam int TW     = 2;
    localparam int NWORDS = 300;
    localparam int LIMIT  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          lnk_valid, lnk_spec;
    logic [DW-1:0] lnk_data;
    logic [TW-1:0] lnk_tag;
    logic          crd_upd = 1'b0, ack_valid = 1'b0, ack_nack = 1'b0;
    logic [TW-1:0] ack_tag = '0;

    spec_credit_tx #(.DATA_W(DW), .SLOTS(SL), .RX_DEPTH(RXD), .TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .lnk_tag(lnk_tag), .lnk_spec(lnk_spec), .crd_upd(crd_upd),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .ack_nack(ack_nack)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0;
    int m_cr, m_pend, m_out, rx_cnt, next_word, n_deliv, cycles;
    int drain_pct, in_pct;
    bit feeding;
    bit delivered [NWORDS];
    bit sent_once [NWORDS];
    bit spec_once [NWORDS];
    bit p_valid, p_ready, p_upd, p_ack, p_nack;
    logic [DW-1:0] p_data;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ready(input int cr, input int pend, input int outst);
        return (outst < SL) && !(cr > 0 && pend > 0);
    endfunction

    // One bench step at a negedge: check the last edge, model it, drive the next
    task automatic step();
        int  pre_cr, pre_p, idx;
        bit  acc, r_valid, r_nack, upd;
        pre_cr = m_cr;
        pre_p  = m_pend;
        acc    = p_valid && p_ready;
        if (acc) next_word++;

        if (pre_cr > 0 && pre_p > 0)
            chk(lnk_valid && !lnk_spec && sent_once[int'(lnk_data) % NWORDS],
                "R6 replay first", int'(lnk_valid), 1);
        else if (acc) begin
            chk(lnk_valid && lnk_data == p_data, "R2 new cell sent", int'(lnk_data), int'(p_data));
            chk(lnk_spec == (pre_cr <= 0), "R4 speculative flag", int'(lnk_spec), int'(pre_cr <= 0));
        end else
            chk(!lnk_valid, "R2 idle link", int'(lnk_valid), 0);

        r_valid = 1'b0;
        r_nack  = 1'b0;
        if (lnk_valid) begin
            idx = int'(lnk_data);
            if (idx >= NWORDS) begin
                chk(1'b0, "R9 payload range", idx, NWORDS - 1);
                idx = 0;
            end
            if (sent_once[idx]) begin
                chk(!lnk_spec, "R5 replay not speculative", int'(lnk_spec), 0);
                m_pend--;
            end
            sent_once[idx] = 1'b1;
            if (lnk_spec) begin
                chk(!spec_once[idx], "R5 one speculative send", 1, 0);
                spec_once[idx] = 1'b1;
            end
            r_valid = 1'b1;
            if (rx_cnt < RXD) begin
                chk(!delivered[idx], "R9 duplicate delivery", 1, 0);
                delivered[idx] = 1'b1;
                n_deliv++;
                rx_cnt++;
            end else begin
                chk(lnk_spec, "R9 credited cell dropped", int'(lnk_spec), 1);
                r_nack = 1'b1;
            end
        end

        m_cr = pre_cr + int'(p_upd) + int'(p_ack && p_nack) - int'(lnk_valid);
        chk(m_cr <= RXD && m_cr >= -SL, "R3 credit window", m_cr, RXD);
        if (acc) m_out++;
        if (p_ack && !p_nack) m_out--;
        if (p_ack && p_nack) m_pend++;

        chk(in_ready == exp_ready(m_cr, m_pend, m_out), "R7 in_ready",
            int'(in_ready), int'(exp_ready(m_cr, m_pend, m_out)));

        upd = 1'b0;
        if (rx_cnt > 0 && $urandom_range(99) < drain_pct) begin
            rx_cnt--;
            upd = 1'b1;
        end
        crd_upd   = upd;
        ack_valid = r_valid;
        ack_nack  = r_nack;
        ack_tag   = lnk_tag;     // R8: tag echoed back
        if (feeding && next_word < NWORDS && $urandom_range(99) < in_pct) begin
            in_valid = 1'b1;
            in_data  = DW'(next_word);
        end else begin
            in_valid = 1'b0;
        end
        p_valid = in_valid;
        p_data  = in_data;
        p_ready = in_ready;
        p_upd   = upd;
        p_ack   = r_valid;
        p_nack  = r_nack;
        cycles++;
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_cr = RXD; m_pend = 0; m_out = 0; rx_cnt = 0;
        next_word = 0; n_deliv = 0; cycles = 0;
        p_valid = 0; p_ready = 0; p_upd = 0; p_ack = 0; p_nack = 0; p_data = '0;
        feeding = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!lnk_valid, "R1 link idle after reset", int'(lnk_valid), 0);
        chk(in_ready, "R1 store empty after reset", int'(in_ready), 1);
        rst_n = 1'b1;

        // Directed: receiver stalled, so credit runs out and speculative cells drop
        drain_pct = 0; in_pct = 100;
        repeat (14) begin @(negedge clk); step(); end
        // Release the drain: credits come back, NACKed cells replay first
        drain_pct = 100; in_pct = 100;
        repeat (12) begin @(negedge clk); step(); end

        // Random phases of drain rate
        while (next_word < NWORDS && cycles < LIMIT) begin
            case ($urandom_range(3))
                0: drain_pct = 5;
                1: drain_pct = 30;
                2: drain_pct = 60;
                default: drain_pct = 100;
            endcase
            in_pct = 40 + $urandom_range(60);
            for (int k = 0; k < 50; k++) begin @(negedge clk); step(); end
        end
        feeding = 1'b0; drain_pct = 100;
        while (n_deliv < NWORDS && cycles < LIMIT) begin @(negedge clk); step(); end
        repeat (10) begin @(negedge clk); step(); end

        chk(cycles < LIMIT, "watchdog", cycles, LIMIT);
        chk(n_deliv == NWORDS, "R9 all delivered", n_deliv, NWORDS);
        chk(m_cr == RXD, "R2 credit restored", m_cr, RXD);
        chk(in_ready, "R7 slots freed by ACK", int'(in_ready), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule